// File: doc/BRIEF.md
# Configuration Lock and Signature Guard

This block stands between a device programmer and the configuration store of a programmable logic device. The programmer sends one command at a time. A command can write a configuration word, read a configuration word back, load or fetch a 64-bit signature word, raise the lock bit, or wipe the whole device. The block keeps the lock bit and the signature register. It decides whether each command is granted. Granted store accesses go out on a request/acknowledge port, and refused commands get a one-cycle error pulse.

The lock bit is sticky. While it is set, configuration reads and writes are refused, and so are signature loads and fetches. Only a wipe clears it, and the same wipe clears the signature. The lock bit can be raised by its own command. It can also be raised automatically when a write flagged as secure and final is acknowledged by the store. The lock bit and the signature model non-volatile state: an ordinary reset leaves them alone, and they start out unlocked and all-zero.

Top module: `cfg_guard`

## Requirements
- R1: After reset, busy, err, done, mem_req, rsp_rdata and sig_rdata are low. Reset does not change the lock bit or the signature. The power-up state is unlocked with an all-zero signature.
- R2: cmd_op encodings are 1 write word, 2 read word, 3 load signature, 4 fetch signature, 5 lock and 6 wipe. A command is accepted on a rising edge where cmd_valid is high and busy is low. While busy is high, cmd_valid is ignored.
- R3: A granted write, read or wipe raises mem_req in the cycle after acceptance. mem_op is 0 for write, 1 for read and 2 for wipe, and mem_addr and mem_wdata come from the command. These stay stable until the edge where mem_ack is sampled high. After that edge, mem_req and busy are low and done is high for one cycle.
- R4: For a granted read, rsp_rdata carries the acknowledged mem_rdata during the done cycle, and is zero otherwise.
- R5: While locked, write word, read word, load signature and fetch signature are refused. err and busy are high for exactly one cycle after acceptance, no mem_req is issued, and sig_rdata and rsp_rdata stay zero.
- R6: A lock command is always granted. In the cycle after acceptance, locked is high and busy and done are each high for one cycle. No store access is made.
- R7: A write word with both cmd_secure and cmd_last set raises locked after its acknowledge edge. With cmd_secure but not cmd_last, the lock bit is unchanged.
- R8: A wipe is granted even when locked. After its acknowledge edge, locked is low and the signature is all-zero.
- R9: When unlocked, a load signature stores sig_wdata. A fetch signature puts the stored value on sig_rdata during its one-cycle done pulse. sig_rdata is zero in every other cycle.
- R10: Opcodes 0 and 7 are always refused, like a locked access: a one-cycle err, no store request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Configuration word address |
| cmd_wdata | input | DW | Configuration word to write |
| cmd_last | input | 1 | Marks the final word of a programming pass |
| cmd_secure | input | 1 | Lock after this word if it is the final one |
| sig_wdata | input | SW | Signature value to load |
| busy | output | 1 | Command in progress |
| err | output | 1 | One-cycle refusal pulse |
| done | output | 1 | One-cycle completion pulse for a granted command |
| rsp_rdata | output | DW | Read word, valid with done |
| sig_rdata | output | SW | Signature, valid with done of a fetch |
| locked | output | 1 | Lock bit state |
| mem_req | output | 1 | Store request |
| mem_op | output | 2 | Store operation |
| mem_addr | output | AW | Store address |
| mem_wdata | output | DW | Store write data |
| mem_ack | input | 1 | Store acknowledge |
| mem_rdata | input | DW | Store read data |

## Verification
Refusals, lock commands and signature operations show their result one cycle after the accepting edge. err or done, busy and sig_rdata are all registered once. Store commands show mem_req in that same cycle, and they finish one cycle after the edge that samples mem_ack, when done, rsp_rdata and the updated lock bit appear together. The bench drives inputs and samples outputs on falling edges only. It checks the first falling edge after acceptance, then polls falling edges until done. The store model in the bench acknowledges after a random delay of zero to three cycles.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

    typedef enum logic [2:0] {
        CMD_NONE  = 3'd0,
        CMD_PROG  = 3'd1,
        CMD_READ  = 3'd2,
        CMD_SIGW  = 3'd3,
        CMD_SIGR  = 3'd4,
        CMD_LOCK  = 3'd5,
        CMD_ERASE = 3'd6,
        CMD_RSVD  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        MOP_WRITE = 2'd0,
        MOP_READ  = 2'd1,
        MOP_ERASE = 2'd2,
        MOP_IDLE  = 2'd3
    } mop_e;

    typedef enum logic [1:0] {
        VERD_REFUSE = 2'd0,
        VERD_LOCAL  = 2'd1,
        VERD_MEM    = 2'd2
    } verdict_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_MEM  = 1'b1
    } seq_st_e;

    typedef struct packed {
        verdict_e verdict;
        mop_e     mop;
        logic     set_lock;
        logic     sig_wr;
        logic     sig_rd;
    } decision_t;

    // Commands that touch protected content and therefore need the lock clear.
    function automatic logic guarded(cmd_e c);
        return (c == CMD_PROG) || (c == CMD_READ) ||
               (c == CMD_SIGW) || (c == CMD_SIGR);
    endfunction

    function automatic mop_e store_op(cmd_e c);
        case (c)
            CMD_PROG:  return MOP_WRITE;
            CMD_READ:  return MOP_READ;
            CMD_ERASE: return MOP_ERASE;
            default:   return MOP_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/cfg_guard_policy.sv
module cfg_guard_policy
    import cfg_guard_pkg::*;
(
    input  logic [2:0] cmd_op,
    input  logic       locked,
    output decision_t  dec
);
    cmd_e c;
    assign c = cmd_e'(cmd_op);

    always_comb begin
        dec = '{verdict: VERD_REFUSE, mop: MOP_IDLE,
                set_lock: 1'b0, sig_wr: 1'b0, sig_rd: 1'b0};
        if (!(guarded(c) && locked)) begin
            case (c)
                CMD_PROG, CMD_READ, CMD_ERASE: begin
                    dec.verdict = VERD_MEM;
                    dec.mop     = store_op(c);
                end
                CMD_SIGW: begin
                    dec.verdict = VERD_LOCAL;
                    dec.sig_wr  = 1'b1;
                end
                CMD_SIGR: begin
                    dec.verdict = VERD_LOCAL;
                    dec.sig_rd  = 1'b1;
                end
                CMD_LOCK: begin
                    dec.verdict  = VERD_LOCAL;
                    dec.set_lock = 1'b1;
                end
                default: dec.verdict = VERD_REFUSE;
            endcase
        end
    end
endmodule

// File: rtl/cfg_guard_secstore.sv
module cfg_guard_secstore #(
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lock_set,
    input  logic          wipe,
    input  logic          sig_we,
    input  logic [SW-1:0] sig_wdata,
    input  logic          sig_rd,
    output logic          locked,
    output logic [SW-1:0] sig_rdata
);
    // Non-volatile state: power-up value is the erased state, reset does not touch it.
    logic          lock_q = 1'b0;
    logic [SW-1:0] sig_q  = '0;
    logic [SW-1:0] sig_out_q;

    always_ff @(posedge clk) begin
        if (wipe) begin
            lock_q <= 1'b0;
            sig_q  <= '0;
        end else begin
            if (lock_set) lock_q <= 1'b1;
            if (sig_we)   sig_q  <= sig_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sig_out_q <= '0;
        else     sig_out_q <= sig_rd ? sig_q : '0;
    end

    assign locked    = lock_q;
    assign sig_rdata = sig_out_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        (lock_q && !wipe) |=> lock_q);  // R8
    AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (!lock_q && sig_q == '0));  // R8
    AST_SIG_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        (sig_out_q != '0) |-> !lock_q);  // R5
endmodule

// File: rtl/cfg_guard_seq.sv
module cfg_guard_seq
    import cfg_guard_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cmd_last,
    input  logic          cmd_secure,
    input  decision_t     dec,
    output logic          busy,
    output logic          err,
    output logic          done,
    output logic [DW-1:0] rsp_rdata,
    output logic          acc_local,
    output logic          fin_lock,
    output logic          fin_wipe,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    seq_st_e       st_q;
    logic          busy_q, err_q, done_q, req_q, seal_q;
    mop_e          mop_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          accept, ack_now;

    assign accept    = !rst && cmd_valid && !busy_q && (st_q == ST_IDLE);
    assign ack_now   = !rst && (st_q == ST_MEM) && mem_ack;
    assign acc_local = accept && (dec.verdict == VERD_LOCAL);
    assign fin_lock  = ack_now && seal_q;
    assign fin_wipe  = ack_now && (mop_q == MOP_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            busy_q  <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            req_q   <= 1'b0;
            seal_q  <= 1'b0;
            mop_q   <= MOP_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            err_q   <= 1'b0;
            done_q  <= 1'b0;
            rdata_q <= '0;
            case (st_q)
                ST_IDLE: begin
                    if (busy_q) begin
                        busy_q <= 1'b0;
                    end else if (cmd_valid) begin
                        busy_q <= 1'b1;
                        case (dec.verdict)
                            VERD_LOCAL: done_q <= 1'b1;
                            VERD_MEM: begin
                                st_q    <= ST_MEM;
                                req_q   <= 1'b1;
                                mop_q   <= dec.mop;
                                addr_q  <= cmd_addr;
                                wdata_q <= cmd_wdata;
                                seal_q  <= (cmd_e'(cmd_op) == CMD_PROG) &&
                                           cmd_secure && cmd_last;
                            end
                            default: err_q <= 1'b1;
                        endcase
                    end
                end
                ST_MEM: begin
                    if (mem_ack) begin
                        st_q   <= ST_IDLE;
                        req_q  <= 1'b0;
                        busy_q <= 1'b0;
                        done_q <= 1'b1;
                        seal_q <= 1'b0;
                        mop_q  <= MOP_IDLE;
                        if (mop_q == MOP_READ) rdata_q <= mem_rdata;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = busy_q;
    assign err       = err_q;
    assign done      = done_q;
    assign rsp_rdata = rdata_q;
    assign mem_req   = req_q;
    assign mem_op    = mop_q;
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        err_q |-> !req_q);  // R5
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        err_q |=> !err_q);  // R5
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (req_q && !mem_ack) |=> (req_q && $stable(addr_q) && $stable(mop_q) && $stable(wdata_q)));  // R3
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_q |-> busy_q);  // R3
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (req_q && mem_ack) |=> (!req_q && !busy_q && done_q));  // R3
    AST_ERR_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(err_q && done_q));  // R10
endmodule

// File: rtl/cfg_guard.sv
module cfg_guard
    import cfg_guard_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16,
    parameter int SW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_wdata,
    input  logic          cmd_last,
    input  logic          cmd_secure,
    input  logic [SW-1:0] sig_wdata,
    output logic          busy,
    output logic          err,
    output logic          done,
    output logic [DW-1:0] rsp_rdata,
    output logic [SW-1:0] sig_rdata,
    output logic          locked,
    output logic          mem_req,
    output logic [1:0]    mem_op,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);
    decision_t dec;
    logic      acc_local, fin_lock, fin_wipe;
    logic      lock_set, sig_we, sig_rd;

    cfg_guard_policy u_policy (
        .cmd_op (cmd_op),
        .locked (locked),
        .dec    (dec)
    );

    cfg_guard_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_wdata  (cmd_wdata),
        .cmd_last   (cmd_last),
        .cmd_secure (cmd_secure),
        .dec        (dec),
        .busy       (busy),
        .err        (err),
        .done       (done),
        .rsp_rdata  (rsp_rdata),
        .acc_local  (acc_local),
        .fin_lock   (fin_lock),
        .fin_wipe   (fin_wipe),
        .mem_req    (mem_req),
        .mem_op     (mem_op),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata)
    );

    assign lock_set = (acc_local && dec.set_lock) || fin_lock;
    assign sig_we   = acc_local && dec.sig_wr;
    assign sig_rd   = acc_local && dec.sig_rd;

    cfg_guard_secstore #(.SW(SW)) u_sec (
        .clk       (clk),
        .rst       (rst),
        .lock_set  (lock_set),
        .wipe      (fin_wipe),
        .sig_we    (sig_we),
        .sig_wdata (sig_wdata),
        .sig_rd    (sig_rd),
        .locked    (locked),
        .sig_rdata (sig_rdata)
    );

    AST_NO_ACCESS_LOCKED: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op != MOP_ERASE) |-> !locked);  // R5
    AST_LOCK_NO_STORE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !busy && cmd_op == CMD_LOCK) |=> (locked && !mem_req));  // R6
endmodule

// File: tb/tb_cfg_guard.sv
module tb_cfg_guard;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int SW = 64;
    localparam int NW = 1 << AW;

    localparam logic [2:0] OP_NONE = 3'd0, OP_PROG = 3'd1, OP_READ = 3'd2,
                           OP_SIGW = 3'd3, OP_SIGR = 3'd4, OP_LOCK = 3'd5,
                           OP_WIPE = 3'd6, OP_RSVD = 3'd7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_wdata = '0;
    logic          cmd_last = 1'b0;
    logic          cmd_secure = 1'b0;
    logic [SW-1:0] sig_wdata = '0;
    logic          busy, err, done, locked, mem_req;
    logic [DW-1:0] rsp_rdata, mem_wdata;
    logic [SW-1:0] sig_rdata;
    logic [1:0]    mem_op;
    logic [AW-1:0] mem_addr;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    cfg_guard #(.AW(AW), .DW(DW), .SW(SW)) dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_last(cmd_last),
        .cmd_secure(cmd_secure), .sig_wdata(sig_wdata), .busy(busy), .err(err),
        .done(done), .rsp_rdata(rsp_rdata), .sig_rdata(sig_rdata), .locked(locked),
        .mem_req(mem_req), .mem_op(mem_op), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Reference state from the requirements
    logic          m_lock = 1'b0;
    logic [SW-1:0] m_sig  = '0;
    logic [DW-1:0] m_mem [NW];
    logic [DW-1:0] store [NW];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Store responder: acknowledges after 0..3 idle cycles
    int dly = 0;
    initial begin
        for (int i = 0; i < NW; i++) store[i] = '1;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                if (dly == 0) begin
                    mem_ack = 1'b1;
                    case (mem_op)
                        2'd0: store[mem_addr] = mem_wdata;
                        2'd1: mem_rdata = store[mem_addr];
                        2'd2: for (int i = 0; i < NW; i++) store[i] = '1;
                        default: ;
                    endcase
                    dly = $urandom_range(0, 3);
                end else begin
                    dly--;
                end
            end
        end
    end

    function automatic bit exp_refuse(input logic [2:0] op, input logic lk);
        if (op == OP_NONE || op == OP_RSVD) return 1'b1;
        if (lk && (op == OP_PROG || op == OP_READ || op == OP_SIGW || op == OP_SIGR)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [1:0] exp_mop(input logic [2:0] op);
        case (op)
            OP_PROG: return 2'd0;
            OP_READ: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // Issue one command at a falling edge and check it to completion.
    // poke_busy presents a lock command while the first one is still busy.
    task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input logic last, input logic sec,
                           input logic [SW-1:0] s, input bit poke_busy);
        bit ref_ = exp_refuse(op, m_lock);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = d;
        cmd_last = last; cmd_secure = sec; sig_wdata = s;
        @(negedge clk);
        cmd_valid = 1'b0;
        if (ref_) begin
            chk(err == 1'b1, (op == OP_NONE || op == OP_RSVD) ? "R10" : "R5", "err after refusal", err, 1);
            chk(busy == 1'b1 && mem_req == 1'b0, "R5", "busy/no req", {busy, mem_req}, 2'b10);
            chk(sig_rdata == '0 && rsp_rdata == '0, "R5", "no data leak", sig_rdata, 0);
            @(negedge clk);
            chk(err == 1'b0 && busy == 1'b0, "R5", "err/busy one cycle", {err, busy}, 0);
        end else if (op == OP_SIGW || op == OP_SIGR || op == OP_LOCK) begin
            chk(done == 1'b1 && busy == 1'b1 && mem_req == 1'b0, "R6", "local op done/busy",
                {done, busy, mem_req}, 3'b110);
            if (op == OP_SIGW) m_sig = s;
            if (op == OP_LOCK) m_lock = 1'b1;
            if (op == OP_SIGR) chk(sig_rdata == m_sig, "R9", "signature fetch", sig_rdata, m_sig);
            if (op == OP_LOCK) chk(locked == 1'b1, "R6", "lock set", locked, 1);
            @(negedge clk);
            chk(done == 1'b0 && busy == 1'b0 && sig_rdata == '0, "R9", "local op ends",
                {done, busy, sig_rdata}, 0);
        end else begin
            int n = 0;
            chk(mem_req == 1'b1 && busy == 1'b1, "R3", "request raised", {mem_req, busy}, 2'b11);
            chk(mem_op == exp_mop(op), "R3", "mem_op", mem_op, exp_mop(op));
            if (op != OP_WIPE) chk(mem_addr == a, "R3", "mem_addr", mem_addr, a);
            if (op == OP_PROG) chk(mem_wdata == d, "R3", "mem_wdata", mem_wdata, d);
            if (poke_busy) begin
                cmd_valid = 1'b1; cmd_op = OP_LOCK;
                @(negedge clk);
                cmd_valid = 1'b0;
                chk(err == 1'b0 && (done || mem_req), "R2", "command ignored while busy",
                    {err, done, mem_req}, 0);
            end
            while (!done && n < 50) begin
                chk(busy == 1'b1, "R3", "busy during request", busy, 1);
                @(negedge clk);
                n++;
            end
            chk(done == 1'b1 && busy == 1'b0 && mem_req == 1'b0, "R3", "ack completes",
                {done, busy, mem_req}, 3'b100);
            case (op)
                OP_PROG: begin
                    m_mem[a] = d;
                    if (sec && last) m_lock = 1'b1;
                end
                OP_READ: chk(rsp_rdata == m_mem[a], "R4", "read data", rsp_rdata, m_mem[a]);
                default: begin
                    for (int i = 0; i < NW; i++) m_mem[i] = '1;
                    m_lock = 1'b0; m_sig = '0;
                end
            endcase
            chk(locked == m_lock, (op == OP_WIPE) ? "R8" : "R7", "lock after ack", locked, m_lock);
            @(negedge clk);
            chk(done == 1'b0 && rsp_rdata == '0, "R4", "done one cycle", {done, rsp_rdata}, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) m_mem[i] = '1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !err && !done && !mem_req && rsp_rdata == '0 && sig_rdata == '0,
            "R1", "reset outputs", {busy, err, done, mem_req}, 0);
        chk(locked == 1'b0, "R1", "power-up unlocked", locked, 0);
        run_cmd(OP_SIGR, 0, 0, 0, 0, 0, 0);                     // R1 zero signature
        run_cmd(OP_NONE, 0, 0, 0, 0, 0, 0);                     // R10
        run_cmd(OP_RSVD, 0, 0, 0, 0, 0, 0);                     // R10
        run_cmd(OP_PROG, 4'd3, 16'hA5C3, 0, 0, 0, 1);           // R2 busy poke
        chk(locked == 1'b0, "R2", "poked lock ignored", locked, 0);
        run_cmd(OP_READ, 4'd3, 0, 0, 0, 0, 0);                  // R4
        run_cmd(OP_SIGW, 0, 0, 0, 0, 64'hDEAD_BEEF_0123_4567, 0); // R9
        run_cmd(OP_SIGR, 0, 0, 0, 0, 0, 0);                     // R9
        // R1: reset keeps the signature
        @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        run_cmd(OP_SIGR, 0, 0, 0, 0, 0, 0);
        // R7: secure without last does not lock; with last it does
        run_cmd(OP_PROG, 4'd7, 16'h1234, 0, 1, 0, 0);
        run_cmd(OP_PROG, 4'd8, 16'h4321, 1, 1, 0, 0);
        run_cmd(OP_READ, 4'd7, 0, 0, 0, 0, 0);                  // R5 refused
        run_cmd(OP_SIGR, 0, 0, 0, 0, 0, 0);                     // R5 refused
        // R1: reset keeps the lock
        @(negedge clk); rst = 1'b1; @(negedge clk); @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk(locked == 1'b1, "R1", "lock kept over reset", locked, 1);
        run_cmd(OP_LOCK, 0, 0, 0, 0, 0, 0);                     // R6 while locked
        run_cmd(OP_WIPE, 0, 0, 0, 0, 0, 0);                     // R8
        run_cmd(OP_SIGR, 0, 0, 0, 0, 0, 0);                     // R8 signature zero
        run_cmd(OP_READ, 4'd8, 0, 0, 0, 0, 0);                  // R8 wiped word
        for (int k = 0; k < 400; k++) begin
            int r = $urandom_range(0, 19);
            logic [2:0] op;
            if (r < 6) op = OP_PROG;
            else if (r < 10) op = OP_READ;
            else if (r < 12) op = OP_SIGW;
            else if (r < 14) op = OP_SIGR;
            else if (r == 14) op = OP_LOCK;
            else if (r == 15) op = OP_WIPE;
            else if (r == 16) op = 3'($urandom_range(0, 1) * 7);
            else op = OP_READ;
            run_cmd(op, AW'($urandom), DW'($urandom), 1'($urandom_range(0, 3) == 0),
                    1'($urandom_range(0, 5) == 0), {32'($urandom), 32'($urandom)},
                    1'($urandom_range(0, 7) == 0));
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule